// File: doc/BRIEF.md
# Backup Battery Load-Test Scheduler

This block decides when a backup cell is put under load and judges the result. It stays idle until the supply supervisor reports that power is good and the post-power-up recovery time is over. It then runs a first test straight away. After that it runs one test each scheduling period. During a test it enables an external load resistor for a fixed window. It reads an external comparator at the last cycle of that window and removes the load at the same point.

A failing test raises the battery warning. The warning is sticky: a later periodic test that passes leaves it set. Only a test that passes straight after a power-up clears it. While power has failed, nothing is scheduled. A test that is running when power fails is dropped without changing the warning. Both periods are parameters in clock cycles, so a short simulation can scale them down from one day and one second.

The warning leaves the block as a pull-down request for an open-drain pin. A value of 1 means pull the pin low, which is the asserted warning. A value of 0 means release the pin. The control pins are plain levels with no handshake, because no data stream passes through the block.

Top module: `bat_test_seq`

## Requirements
- R1: While `rst_n` is low, and after reset until a test starts, `load_en` is 0 and `warn_pd` is 0.
- R2: No test starts while `recover_done` is 0. When `recover_done` is 1 and `pwr_fail` is 0 at a clock edge while powered down, `load_en` is 1 from that edge onward.
- R3: While `pwr_fail` is 1, `load_en` is 0, in the same cycle that `pwr_fail` rises. The periodic schedule is suspended however long the failure lasts.
- R4: For each test that is not aborted, `load_en` is 1 for exactly LOAD_CYC consecutive cycles.
- R5: `batt_low` is sampled in the last cycle of the load window. If it is 1 there, `warn_pd` is 1 from the next cycle.
- R6: A periodic test whose sample is 0 leaves `warn_pd` unchanged, so a set warning stays set.
- R7: The first test after a power-up clears `warn_pd` to 0 when its sample is 0.
- R8: The cycle in which `load_en` first returns to 0 is counted as cycle 0. The next periodic test raises `load_en` at cycle PERIOD_CYC.
- R9: `batt_low` has no effect outside the last cycle of a load window.
- R10: A power failure during a window aborts the test and leaves `warn_pd` unchanged. When power is good again, a full power-up test runs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| recover_done | input | 1 | Supervisor: supply good and recovery time elapsed |
| pwr_fail | input | 1 | Supervisor: supply out of tolerance |
| batt_low | input | 1 | Comparator: cell below trip level under load |
| load_en | output | 1 | Connects the test resistor across the cell |
| warn_pd | output | 1 | Open-drain warning: 1 pulls the pin low (asserted) |

## Verification
On every cycle, the assertions check the following:
- A failure forces the sequencer to its powered-down state.
- No test begins before recovery is reported.
- A low sample at the end of a window sets the warning.
- The warning only falls after a power-up test.
- The warning holds between sample points.
- The window counters stay in range.

Only the bench scenarios can show the exact window length and the exact spacing between periodic tests. They also show the chain of results across power cycles: sticky through passing periodic tests, cleared by a passing power-up test. They also show that an aborted test leaves the warning as it was and is replaced by a full new test.

// File: rtl/bts_pkg.sv
package bts_pkg;
  typedef enum logic [1:0] {
    ST_OFF  = 2'd0,
    ST_WAIT = 2'd1,
    ST_LOAD = 2'd2
  } bts_state_e;
endpackage

// File: rtl/bts_span_timer.sv
module bts_span_timer #(
  parameter longint unsigned SPAN = 64'd8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic last
);
  localparam int W = (SPAN > 64'd1) ? $clog2(SPAN) : 1;
  localparam logic [W-1:0] LAST_VAL = W'(SPAN - 64'd1);

  logic [W-1:0] cnt;

  assign last = run && (cnt == LAST_VAL);

  always_ff @(posedge clk) begin
    if (!rst_n)
      cnt <= '0;
    else if (!run || last)
      cnt <= '0;
    else
      cnt <= cnt + 1'b1;
  end

  AST_SPAN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (64'(cnt) < SPAN)) else $error("span counter out of range"); // R4

  AST_IDLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt == '0)) else $error("span counter kept count while idle"); // R8
endmodule

// File: rtl/bts_warn_reg.sv
module bts_warn_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic sample,
  input  logic fail,
  input  logic may_clear,
  output logic warn
);
  always_ff @(posedge clk) begin
    if (!rst_n)
      warn <= 1'b0;
    else if (sample) begin
      if (fail)
        warn <= 1'b1;
      else if (may_clear)
        warn <= 1'b0;
    end
  end

  AST_WARN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !sample |=> $stable(warn)) else $error("warning moved outside a sample point"); // R9
endmodule

// File: rtl/bat_test_seq.sv
module bat_test_seq #(
  parameter longint unsigned PERIOD_CYC = 64'd21600000000000,
  parameter longint unsigned LOAD_CYC   = 64'd250000000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic recover_done,
  input  logic pwr_fail,
  input  logic batt_low,
  output logic load_en,
  output logic warn_pd
);
  import bts_pkg::*;

  bts_state_e state, nxt;
  logic pu_test;
  logic per_run, per_due;
  logic win_last;
  logic warn_q;

  assign load_en = (state == ST_LOAD) && !pwr_fail;
  assign per_run = (state == ST_WAIT) && !pwr_fail;
  assign warn_pd = warn_q;

  always_comb begin
    nxt = state;
    if (pwr_fail)
      nxt = ST_OFF;
    else begin
      case (state)
        ST_OFF:  if (recover_done) nxt = ST_LOAD;
        ST_WAIT: if (per_due)      nxt = ST_LOAD;
        ST_LOAD: if (win_last)     nxt = ST_WAIT;
        default: nxt = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_OFF;
      pu_test <= 1'b0;
    end else begin
      state <= nxt;
      if (state == ST_OFF && nxt == ST_LOAD)
        pu_test <= 1'b1;
      else if (state == ST_WAIT && nxt == ST_LOAD)
        pu_test <= 1'b0;
    end
  end

  bts_span_timer #(.SPAN(PERIOD_CYC)) u_period (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (per_run),
    .last (per_due)
  );

  bts_span_timer #(.SPAN(LOAD_CYC)) u_window (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (load_en),
    .last (win_last)
  );

  bts_warn_reg u_warn (
    .clk      (clk),
    .rst_n    (rst_n),
    .sample   (win_last),
    .fail     (batt_low),
    .may_clear(pu_test),
    .warn     (warn_q)
  );

  AST_FAIL_FORCES_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_fail |=> (state == ST_OFF)) else $error("failure did not stop sequencing"); // R3

  AST_NO_EARLY_TEST: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_OFF && !recover_done) |=> !load_en) else $error("test before recovery"); // R2

  AST_LOW_SETS_WARN: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state == ST_LOAD) && state == ST_WAIT && $past(batt_low)) |-> warn_pd)
    else $error("low sample did not raise warning"); // R5

  AST_STICKY_WARN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(warn_pd) |-> $past(pu_test)) else $error("periodic test cleared warning"); // R6
endmodule

// File: tb/sim_bat_test_seq.sv
module sim_bat_test_seq;
  localparam int PER = 40;
  localparam int WIN = 8;
  // vector bits: {power-up test, batt_low during window, expected warn_pd}
  localparam logic [2:0] VEC [0:6] = '{3'b100, 3'b011, 3'b001, 3'b111,
                                       3'b100, 3'b011, 3'b100};

  logic clk = 1'b0;
  logic rst_n, recover_done, pwr_fail, batt_low;
  logic load_en, warn_pd;
  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  bat_test_seq #(.PERIOD_CYC(PER), .LOAD_CYC(WIN)) u0 (
    .clk(clk), .rst_n(rst_n), .recover_done(recover_done), .pwr_fail(pwr_fail),
    .batt_low(batt_low), .load_en(load_en), .warn_pd(warn_pd)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic measure_gap(output int g);
    g = 0;
    while (!load_en && g < 10 * PER) begin
      @(negedge clk);
      g++;
    end
  endtask

  task automatic measure_win(output int w);
    w = 1;
    forever begin
      @(negedge clk);
      if (!load_en || w > 4 * WIN) break;
      w++;
    end
  endtask

  task automatic power_cycle(input int hold);
    bit bad;
    bad = 0;
    @(negedge clk);
    pwr_fail = 1'b1;
    recover_done = 1'b0;
    #1 if (load_en) bad = 1;
    for (int k = 0; k < hold; k++) begin
      @(negedge clk);
      if (load_en) bad = 1;
    end
    chk(!bad, "R3", bad, 0);
    pwr_fail = 1'b0;
    repeat (3) @(negedge clk);
    chk(load_en == 1'b0, "R2", load_en, 0);
    recover_done = 1'b1;
    @(negedge clk);
    chk(load_en == 1'b1, "R2", load_en, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int g, w;
    rst_n = 1'b0; recover_done = 1'b0; pwr_fail = 1'b0; batt_low = 1'b0;
    repeat (3) @(negedge clk);
    chk(load_en == 1'b0, "R1", load_en, 0);
    chk(warn_pd == 1'b0, "R1", warn_pd, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(load_en == 1'b0 && warn_pd == 1'b0, "R1", {load_en, warn_pd}, 0);

    for (int i = 0; i < 7; i++) begin
      logic [2:0] v;
      v = VEC[i];
      batt_low = v[1];
      if (v[2])
        power_cycle(PER + 5);
      else begin
        measure_gap(g);
        chk(g == PER, "R8", g, PER);
      end
      measure_win(w);
      chk(w == WIN, "R4", w, WIN);
      chk(warn_pd == v[0], v[2] ? "R7" : "R6", warn_pd, v[0]);
    end

    // only the last window cycle counts: low before, good at the end
    batt_low = 1'b1;
    measure_gap(g);
    chk(g == PER, "R8", g, PER);
    w = 1;
    forever begin
      if (w == WIN) batt_low = 1'b0;
      @(negedge clk);
      if (!load_en || w > 4 * WIN) break;
      w++;
    end
    chk(warn_pd == 1'b0, "R9", warn_pd, 0);

    // good during the window, low only at its last cycle
    measure_gap(g);
    w = 1;
    forever begin
      if (w == WIN) batt_low = 1'b1;
      @(negedge clk);
      if (!load_en || w > 4 * WIN) break;
      w++;
    end
    chk(warn_pd == 1'b1, "R5", warn_pd, 1);
    batt_low = 1'b0;

    // abort a power-up test that would otherwise clear the warning
    power_cycle(5);
    repeat (3) @(negedge clk);
    pwr_fail = 1'b1;
    #1 chk(load_en == 1'b0, "R3", load_en, 0);
    @(negedge clk);
    chk(warn_pd == 1'b1, "R10", warn_pd, 1);
    pwr_fail = 1'b0;
    @(negedge clk);
    chk(load_en == 1'b1, "R10", load_en, 1);
    measure_win(w);
    chk(w == WIN, "R10", w, WIN);
    chk(warn_pd == 1'b0, "R7", warn_pd, 0);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule